// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances by one on every clock where the count enable is high. Two general registers, A and B, watch that counter. Each one works as an output compare register or as an input capture register, depending on its own 4-bit field in an 8-bit I/O control register.

In compare mode, a register drives its own output pin. The pin starts at a programmed level. When the counter reaches the register value, the pin is driven low, driven high or inverted. In capture mode, the register takes a copy of the counter in one of two cases. The first is a chosen edge of its own (synchronized) input pin. The second is an event strobe from a neighbouring channel. Every compare match or capture sets a per-register flag. Software clears a flag by writing a one to it.

Software sets compare values through a write port for the general registers. It reads captured values from the register outputs.

Top module: `capcmp_channel`

## Requirements
- R1: The control register is 8 bits wide and resets to 0x00. Bits 3:0 are the field for register A and bits 7:4 are the field for register B. A write with `cfgWe` stores all 8 bits, and `cfgRdata` returns them on the next clock.
- R2: The counter is 16 bits wide and resets to 0. It increases by one on each clock with `cntEn` high, holds its value while `cntEn` is low, and wraps from 0xFFFF to 0x0000.
- R3: When a field has bit 3 = 0 (compare mode) and bits 1:0 ≠ 00, the pin output enable is high. A control write that stores such a field sets the pin to the level in bit 2 on the next clock. When bits 1:0 = 00, or bit 3 = 1 (capture mode), the output enable is low.
- R4: In compare mode, the clock edge that follows the first cycle in which the counter equals the general register does two things. It sets the flag, and it applies the action in bits 1:0: 01 drives 0, 10 drives 1, 11 inverts the pin, and 00 leaves the pin released. While the equality persists there is no second match. The equality that exists at reset does not count as a match.
- R5: In capture mode with bit 2 = 0, bits 1:0 select the trigger edge of the register's own pin: 00 is rising, 01 is falling, 10 or 11 is either edge. The pin passes through a two-flop synchronizer. The captured value is the counter value two clocks after the pin change, and the flag sets on the same edge as the capture.
- R6: In capture mode with bit 2 = 1, register A captures on `nbrEvtA` and register B captures on `nbrEvtC`. The pins and the other strobe have no effect. The captured value is the counter value in the cycle of the strobe.
- R7: Writing a one to a bit of `flagClr` clears that flag only. If an event arrives in the same clock as the clear, the flag stays set.
- R8: A software write loads the general register on the next clock. If a capture happens in the same clock, the capture wins.
- R9: After reset, the flags, both output enables, both pin levels and both general registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Counter advance enable |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 8 | Control register write data |
| cfgRdata | output | 8 | Control register contents |
| grWeA | input | 1 | Software write of general register A |
| grWeB | input | 1 | Software write of general register B |
| grWdata | input | 16 | General register write data |
| grValA | output | 16 | General register A contents |
| grValB | output | 16 | General register B contents |
| cntVal | output | 16 | Counter value |
| pinInA | input | 1 | Capture pin for A (asynchronous) |
| pinInB | input | 1 | Capture pin for B (asynchronous) |
| nbrEvtA | input | 1 | Neighbour channel's A event strobe |
| nbrEvtC | input | 1 | Neighbour channel's C event strobe |
| pinOutA | output | 1 | Output level for pin A |
| pinOutB | output | 1 | Output level for pin B |
| pinOeA | output | 1 | Output enable for pin A |
| pinOeB | output | 1 | Output enable for pin B |
| flagClr | input | 2 | Write-one-to-clear for flags (bit 0 = A, bit 1 = B) |
| flags | output | 2 | Event flags (bit 0 = A, bit 1 = B) |

## Verification
The hardest case to reach from the ports is the moment when the counter sits exactly on the compare value. This case must be hit once, and then held without a second match. The bench parks the counter with `cntEn` low. It loads the register three counts ahead, runs exactly three enabled clocks, and then stops the counter on the equal value. This isolates the single match edge and lets the bench watch the cycles that follow for repeats. Every compare and capture code of both fields is swept this way. Each capture is placed against a counter value read at the moment the stimulus is applied.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  localparam int GR_COUNT = 2;
  localparam int FIELD_W  = 4;
  localparam int CFG_W    = GR_COUNT * FIELD_W;

  // one control field per general register
  typedef struct packed {
    logic       isCap;   // 1: input capture, 0: output compare
    logic       auxBit;  // compare: initial level; capture: neighbour source
    logic [1:0] sel;     // compare: pin action; capture: edge choice
  } ioField_t;

  // strobes sent from control to datapath
  typedef struct packed {
    logic [GR_COUNT-1:0] capLoad;
    logic [GR_COUNT-1:0] swLoad;
  } dpStrobe_t;

  function automatic logic drivesPin(input ioField_t f);
    return !f.isCap && (f.sel != 2'b00);
  endfunction

  function automatic logic captureHit(input ioField_t f, input logic rise,
                                      input logic fall, input logic nbr);
    logic hit;
    if (!f.isCap)      hit = 1'b0;
    else if (f.auxBit) hit = nbr;
    else begin
      case (f.sel)
        2'b00:   hit = rise;
        2'b01:   hit = fall;
        default: hit = rise | fall;
      endcase
    end
    return hit;
  endfunction

endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cntEn,
  input  dpStrobe_t                          strobe,
  input  logic [CNT_W-1:0]                   grWdata,
  input  logic [GR_COUNT-1:0]                pinIn,
  output logic [CNT_W-1:0]                   cntVal,
  output logic [GR_COUNT-1:0][CNT_W-1:0]     grVal,
  output logic [GR_COUNT-1:0]                matchHit,
  output logic [GR_COUNT-1:0]                riseSeen,
  output logic [GR_COUNT-1:0]                fallSeen
);

  localparam int SYNC_LEN = 3;  // two sync stages plus one history stage

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cntQ <= '0;
    else if (cntEn) cntQ <= cntQ + 1'b1;
  end

  assign cntVal = cntQ;

  for (genvar g = 0; g < GR_COUNT; g++) begin : g_reg
    logic [SYNC_LEN-1:0] syncQ;
    logic [CNT_W-1:0]    grQ;
    logic                eqPrev;
    logic                eqNow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_LEN-2:0], pinIn[g]};
    end

    assign riseSeen[g] = syncQ[SYNC_LEN-2] & ~syncQ[SYNC_LEN-1];
    assign fallSeen[g] = ~syncQ[SYNC_LEN-2] & syncQ[SYNC_LEN-1];

    assign eqNow = (cntQ == grQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) eqPrev <= 1'b1;  // equality present at reset is not an arrival
      else       eqPrev <= eqNow;
    end

    assign matchHit[g] = eqNow & ~eqPrev;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    grQ <= '0;
      else if (strobe.capLoad[g])   grQ <= cntQ;
      else if (strobe.swLoad[g])    grQ <= grWdata;
    end

    assign grVal[g] = grQ;
  end

endmodule

// File: rtl/capcmp_control.sv
module capcmp_control
  import capcmp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWdata,
  input  logic [GR_COUNT-1:0] grWe,
  input  logic [GR_COUNT-1:0] flagClr,
  input  logic [GR_COUNT-1:0] nbrEvt,
  input  logic [GR_COUNT-1:0] matchHit,
  input  logic [GR_COUNT-1:0] riseSeen,
  input  logic [GR_COUNT-1:0] fallSeen,
  output logic [CFG_W-1:0]    cfgQ,
  output dpStrobe_t           strobe,
  output logic [GR_COUNT-1:0] flagQ,
  output logic [GR_COUNT-1:0] pinLvl,
  output logic [GR_COUNT-1:0] pinOe
);

  logic [GR_COUNT-1:0] capV;
  logic [GR_COUNT-1:0] swV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata;
  end

  for (genvar g = 0; g < GR_COUNT; g++) begin : g_ctl
    ioField_t curF;
    ioField_t newF;
    logic     capHit;
    logic     cmpHit;

    assign curF   = ioField_t'(cfgQ[g*FIELD_W +: FIELD_W]);
    assign newF   = ioField_t'(cfgWdata[g*FIELD_W +: FIELD_W]);
    assign capHit = captureHit(curF, riseSeen[g], fallSeen[g], nbrEvt[g]);
    assign cmpHit = !curF.isCap && matchHit[g];

    // capture takes precedence over a software load
    assign capV[g] = capHit;
    assign swV[g]  = grWe[g] & ~capHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   flagQ[g] <= 1'b0;
      else if (capHit || cmpHit)   flagQ[g] <= 1'b1;
      else if (flagClr[g])         flagQ[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinLvl[g] <= 1'b0;
      else if (cfgWe && drivesPin(newF)) pinLvl[g] <= newF.auxBit;
      else if (cmpHit) begin
        case (curF.sel)
          2'b01:   pinLvl[g] <= 1'b0;
          2'b10:   pinLvl[g] <= 1'b1;
          2'b11:   pinLvl[g] <= ~pinLvl[g];
          default: pinLvl[g] <= pinLvl[g];
        endcase
      end
    end

    assign pinOe[g] = drivesPin(curF);
  end

  assign strobe.capLoad = capV;
  assign strobe.swLoad  = swV;

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             cfgWe,
  input  logic [7:0]       cfgWdata,
  output logic [7:0]       cfgRdata,
  input  logic             grWeA,
  input  logic             grWeB,
  input  logic [CNT_W-1:0] grWdata,
  output logic [CNT_W-1:0] grValA,
  output logic [CNT_W-1:0] grValB,
  output logic [CNT_W-1:0] cntVal,
  input  logic             pinInA,
  input  logic             pinInB,
  input  logic             nbrEvtA,
  input  logic             nbrEvtC,
  output logic             pinOutA,
  output logic             pinOutB,
  output logic             pinOeA,
  output logic             pinOeB,
  input  logic [1:0]       flagClr,
  output logic [1:0]       flags
);

  dpStrobe_t                         strobe;
  logic [GR_COUNT-1:0][CNT_W-1:0]    grVal;
  logic [GR_COUNT-1:0]               matchHit;
  logic [GR_COUNT-1:0]               riseSeen;
  logic [GR_COUNT-1:0]               fallSeen;
  logic [GR_COUNT-1:0]               pinLvl;
  logic [GR_COUNT-1:0]               pinOe;

  capcmp_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cntEn    (cntEn),
    .strobe   (strobe),
    .grWdata  (grWdata),
    .pinIn    ({pinInB, pinInA}),
    .cntVal   (cntVal),
    .grVal    (grVal),
    .matchHit (matchHit),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen)
  );

  capcmp_control ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .grWe     ({grWeB, grWeA}),
    .flagClr  (flagClr),
    .nbrEvt   ({nbrEvtC, nbrEvtA}),
    .matchHit (matchHit),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .cfgQ     (cfgRdata),
    .strobe   (strobe),
    .flagQ    (flags),
    .pinLvl   (pinLvl),
    .pinOe    (pinOe)
  );

  assign grValA  = grVal[0];
  assign grValB  = grVal[1];
  assign pinOutA = pinLvl[0];
  assign pinOutB = pinLvl[1];
  assign pinOeA  = pinOe[0];
  assign pinOeB  = pinOe[1];

endmodule

// File: rtl/capcmp_channel_chk.sv
module capcmp_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             cfgWe,
  input logic [7:0]       cfgWdata,
  input logic [7:0]       cfgRdata,
  input logic [CNT_W-1:0] grValA,
  input logic [CNT_W-1:0] grValB,
  input logic [CNT_W-1:0] cntVal,
  input logic             nbrEvtA,
  input logic             nbrEvtC,
  input logic             pinOutA,
  input logic             pinOeA,
  input logic [1:0]       flagClr,
  input logic [1:0]       flags
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> (cntVal == $past(cntVal) + 1'b1)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(cntVal)); // R2

  AST_INIT_LEVEL_A: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgWdata[3] && cfgWdata[1:0] != 2'b00)
      |=> (pinOeA && pinOutA == $past(cfgWdata[2]))); // R3

  AST_MATCH_SOURCE_A: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[0] && !cfgRdata[3]) |=> (flags[0] -> $past(cntVal == grValA))); // R4

  AST_NBR_CAPTURE_A: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[3:2] == 2'b11 && nbrEvtA)
      |=> (grValA == $past(cntVal) && flags[0])); // R6

  AST_NBR_CAPTURE_B: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[7:6] == 2'b11 && nbrEvtC)
      |=> (grValB == $past(cntVal) && flags[1])); // R6

  AST_FLAG_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !flagClr[0]) |=> flags[0]); // R7

  AST_FLAG_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !flagClr[1]) |=> flags[1]); // R7

endmodule

bind capcmp_channel capcmp_channel_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/capcmp_channel_tb_top.sv
module capcmp_channel_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        grWeA = 1'b0;
  logic        grWeB = 1'b0;
  logic [15:0] grWdata = '0;
  logic [15:0] grValA, grValB, cntVal;
  logic        pinInA = 1'b0;
  logic        pinInB = 1'b0;
  logic        nbrEvtA = 1'b0;
  logic        nbrEvtC = 1'b0;
  logic        pinOutA, pinOutB, pinOeA, pinOeB;
  logic [1:0]  flagClr = '0;
  logic [1:0]  flags;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_channel dut_i (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic oeOf(input int g);
    return (g == 0) ? pinOeA : pinOeB;
  endfunction
  function automatic logic lvlOf(input int g);
    return (g == 0) ? pinOutA : pinOutB;
  endfunction
  function automatic logic [15:0] grOf(input int g);
    return (g == 0) ? grValA : grValB;
  endfunction

  task automatic writeCfg(input logic [7:0] v);
    cfgWe = 1'b1; cfgWdata = v; tick(); cfgWe = 1'b0;
  endtask
  task automatic writeGr(input int g, input logic [15:0] v);
    grWdata = v;
    if (g == 0) grWeA = 1'b1; else grWeB = 1'b1;
    tick(); grWeA = 1'b0; grWeB = 1'b0;
  endtask
  task automatic clrFlags();
    flagClr = 2'b11; tick(); flagClr = 2'b00;
  endtask
  task automatic setPin(input int g, input logic v);
    if (g == 0) pinInA = v; else pinInB = v;
  endtask
  task automatic pulseNbr(input int g);
    if (g == 0) nbrEvtA = 1'b1; else nbrEvtC = 1'b1;
    tick(); nbrEvtA = 1'b0; nbrEvtC = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=done", WATCHDOG);
    summary();
  end

  initial begin
    logic [15:0] c, gOld;
    logic        expLvl, initLvl, hit;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // reset state
    chk("R9", "cfg",    cfgRdata, 8'h00);
    chk("R9", "flags",  flags,    2'b00);
    chk("R9", "oe",     {pinOeB, pinOeA},   2'b00);
    chk("R9", "pins",   {pinOutB, pinOutA}, 2'b00);
    chk("R9", "grA",    grValA, 16'h0);
    chk("R9", "grB",    grValB, 16'h0);
    chk("R2", "cnt reset", cntVal, 16'h0);
    repeat (3) tick();
    chk("R4", "no match at reset equality", flags, 2'b00);

    // control register readback
    writeCfg(8'hA5);
    chk("R1", "readback A5", cfgRdata, 8'hA5);
    writeCfg(8'h5A);
    chk("R1", "readback 5A", cfgRdata, 8'h5A);
    writeCfg(8'h00);

    // counter step and hold
    c = cntVal;
    repeat (5) tick();
    chk("R2", "hold", cntVal, c);
    cntEn = 1'b1;
    repeat (7) tick();
    chk("R2", "step", cntVal, c + 16'd7);
    cntEn = 1'b0;

    // compare sweep over every compare code of both fields
    for (int g = 0; g < 2; g++) begin
      for (int code = 0; code < 8; code++) begin
        writeCfg(8'(code << (4 * g)));
        initLvl = code[2];
        chk("R3", "oe after cfg", oeOf(g), (code[1:0] != 2'b00));
        if (code[1:0] != 2'b00) chk("R3", "initial level", lvlOf(g), initLvl);
        c = cntVal;
        writeGr(g, c + 16'd3);
        clrFlags();
        chk("R4", "flag idle", flags[g], 1'b0);
        cntEn = 1'b1;
        tick(); tick(); tick();
        cntEn = 1'b0;
        chk("R4", "no early match", flags[g], 1'b0);
        tick();
        chk("R4", "match flag", flags[g], 1'b1);
        case (code[1:0])
          2'b01:   expLvl = 1'b0;
          2'b10:   expLvl = 1'b1;
          2'b11:   expLvl = ~initLvl;
          default: expLvl = 1'b0;
        endcase
        if (code[1:0] != 2'b00) chk("R4", "match action", lvlOf(g), expLvl);
        else                    chk("R4", "disabled stays released", oeOf(g), 1'b0);
        clrFlags();
        tick(); tick();
        chk("R4", "single match", flags[g], 1'b0);
        if (code[1:0] != 2'b00) chk("R4", "pin held", lvlOf(g), expLvl);
      end
    end

    // capture sweep over every capture code of both fields
    cntEn = 1'b1;
    for (int g = 0; g < 2; g++) begin
      for (int code = 8; code < 16; code++) begin
        writeCfg(8'(code << (4 * g)));
        chk("R3", "oe in capture", oeOf(g), 1'b0);
        repeat (4) tick();
        clrFlags();
        gOld = grOf(g);
        if (code[2] == 1'b0) begin
          c = cntVal; setPin(g, 1'b1);
          tick(); tick(); tick();
          hit = (code[1:0] != 2'b01);
          chk("R5", "rise flag", flags[g], hit);
          chk("R5", "rise value", grOf(g), hit ? c + 16'd2 : gOld);
          clrFlags();
          gOld = grOf(g);
          c = cntVal; setPin(g, 1'b0);
          tick(); tick(); tick();
          hit = (code[1:0] != 2'b00);
          chk("R5", "fall flag", flags[g], hit);
          chk("R5", "fall value", grOf(g), hit ? c + 16'd2 : gOld);
        end else begin
          setPin(g, 1'b1); repeat (4) tick();
          setPin(g, 1'b0); repeat (4) tick();
          pulseNbr(1 - g);
          tick();
          chk("R6", "pin and other strobe ignored", flags[g], 1'b0);
          chk("R6", "value untouched", grOf(g), gOld);
          c = cntVal;
          pulseNbr(g);
          chk("R6", "strobe flag", flags[g], 1'b1);
          chk("R6", "strobe value", grOf(g), c);
        end
        clrFlags();
      end
    end

    // flag priority and per-bit clear
    writeCfg(8'hCC);
    clrFlags();
    nbrEvtA = 1'b1; flagClr = 2'b01;
    tick();
    nbrEvtA = 1'b0; flagClr = 2'b00;
    chk("R7", "event beats clear", flags[0], 1'b1);
    nbrEvtC = 1'b1; tick(); nbrEvtC = 1'b0;
    chk("R7", "both set", flags, 2'b11);
    flagClr = 2'b01; tick(); flagClr = 2'b00;
    chk("R7", "clear A only", flags, 2'b10);

    // capture versus software load
    c = cntVal;
    nbrEvtA = 1'b1; grWeA = 1'b1; grWdata = 16'h1234;
    tick();
    nbrEvtA = 1'b0; grWeA = 1'b0;
    chk("R8", "capture wins", grValA, c);
    writeGr(0, 16'hBEEF);
    chk("R8", "software load", grValA, 16'hBEEF);

    // wrap of the counter
    for (int i = 0; i < 70000 && cntVal != 16'hFFFF; i++) tick();
    chk("R2", "reach top", cntVal, 16'hFFFF);
    tick();
    chk("R2", "wrap", cntVal, 16'h0000);

    summary();
  end

endmodule